// File: doc/BRIEF.md
# Single-Source NMI Line Controller

This block takes one asynchronous external interrupt line, watches it for a
programmable trigger condition, latches each detected event in a sticky
pending flag and raises a request toward a parent interrupt controller while
that flag is set and the line is unmasked. Software reaches it through a
plain register bus of three 32-bit registers: trigger control, pending and
enable.

The trigger field selects active-low level, falling edge, active-high level
or rising edge. The raw line passes through a flop synchronizer. In a level
mode the pending flag is set again on every cycle the line stays active.
Driver software must therefore clear the flag after the source has been
serviced and before unmasking. Otherwise a second request follows at once.
The byte offset of the enable register is a parameter, so one netlist serves
both register layouts in use.

The bus is a single-cycle register port with no back-pressure. A write takes
effect on the clock edge where `bus_sel` and `bus_wr` are both high. Read data
is combinational from the address while `bus_sel` is high and `bus_wr` is
low. The interrupt pins are plain level signals with no handshake.

Top module: `nmi_line_ctrl`

## Requirements
- R1: After reset the control, pending and enable registers all read 0 and `irq_out` is 0. The synchronizer resets to the inactive level of the default mode (1), so an idle-high line sets nothing.
- R2: The control register at offset 0x00 stores and reads back all 32 written bits. Its bits [1:0] select the trigger: 0 active-low level, 1 falling edge, 2 active-high level, 3 rising edge.
- R3: A change on `irq_in` passes two synchronizer flops before detection. The pending flag reflects it after the third rising clock edge following the change.
- R4: In a level mode the pending flag is set on every cycle the synchronized line is active. A clear written while it stays active leaves the flag at 1, because a set wins over a clear in the same cycle.
- R5: In an edge mode only the selected transition sets the pending flag. A line held steady after the transition does not set it again once it is cleared.
- R6: The pending register at offset 0x04 reads the flag in bit 0, with all other bits 0. Writing 1 to bit 0 clears the flag, and writing 0 to bit 0 leaves it unchanged.
- R7: The enable register sits at offset `EN_OFFSET` (0x08 by default, 0x34 in the alternate layout). It stores bit 0 only, where 1 unmasks and 0 masks; its other bits read 0.
- R8: `irq_out` is registered and equals (pending AND enable) as held one cycle earlier.
- R9: Reads of any other offset return 0. Writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| irq_in | input | 1 | Asynchronous external interrupt line |
| irq_out | output | 1 | Request to the parent interrupt controller |

## Verification
On every cycle, the assertions check four things. The request output tracks the previous cycle's pending-and-enable product. A detected event always leaves the flag set on the next cycle, even against a clear. The flag holds unless it is cleared, and it drops on a clear that meets no event. Unmapped reads return zero and enable writes land. The bench sweeps every trigger mode against every old/new line level and both mask states. Only those scenarios show the two-flop detection latency, edge-versus-level re-arming after a clear, the mode encoding, and the full-width control readback.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LO = 2'd0,
    TRIG_FALL   = 2'd1,
    TRIG_LVL_HI = 2'd2,
    TRIG_RISE   = 2'd3
  } trig_e;

  localparam int unsigned CTRL_OFF  = 32'h00;
  localparam int unsigned PEND_OFF  = 32'h04;
  localparam int unsigned EN_OFF_A  = 32'h08;
  localparam int unsigned EN_OFF_B  = 32'h34;

  localparam int unsigned TRIG_LSB  = 0;
  localparam int unsigned TRIG_W    = 2;

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RST_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_LEVEL;
          else        stage_q[g] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_LEVEL;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/nmi_detect.sv
module nmi_detect
  import nmi_pkg::*;
#(
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  line_sync,
  input  trig_e trig,
  output logic  event_o
);

  logic prev_q;
  logic rise_w;
  logic fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_LEVEL;
    else        prev_q <= line_sync;
  end

  assign rise_w = line_sync & ~prev_q;
  assign fall_w = ~line_sync & prev_q;

  always_comb begin
    unique case (trig)
      TRIG_LVL_LO: event_o = ~line_sync;
      TRIG_FALL:   event_o = fall_w;
      TRIG_LVL_HI: event_o = line_sync;
      TRIG_RISE:   event_o = rise_w;
      default:     event_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/nmi_regs.sv
module nmi_regs
  import nmi_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned EN_OFFSET = EN_OFF_A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              event_i,
  output trig_e             trig_o,
  output logic              pend_o,
  output logic              en_o
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(PEND_OFF);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_OFFSET);

  logic [DATA_W-1:0] ctrl_q;
  logic              pend_q;
  logic              en_q;
  logic              hit_ctrl, hit_pend, hit_en;
  logic              wr_ctrl, wr_pend, wr_en;
  logic              clr_w;

  assign hit_ctrl = (bus_addr == A_CTRL);
  assign hit_pend = (bus_addr == A_PEND);
  assign hit_en   = (bus_addr == A_EN);

  assign wr_ctrl = bus_sel & bus_wr & hit_ctrl;
  assign wr_pend = bus_sel & bus_wr & hit_pend;
  assign wr_en   = bus_sel & bus_wr & hit_en;
  assign clr_w   = wr_pend & bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata;
  end

  // a detected event takes precedence over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (event_i) pend_q <= 1'b1;
    else if (clr_w)   pend_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (wr_en) en_q <= bus_wdata[0];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (hit_ctrl)      bus_rdata = ctrl_q;
      else if (hit_pend) bus_rdata = DATA_W'(pend_q);
      else if (hit_en)   bus_rdata = DATA_W'(en_q);
    end
  end

  assign trig_o = trig_e'(ctrl_q[TRIG_LSB +: TRIG_W]);
  assign pend_o = pend_q;
  assign en_o   = en_q;

endmodule

// File: rtl/nmi_line_ctrl.sv
module nmi_line_ctrl
  import nmi_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned EN_OFFSET   = EN_OFF_A,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_in,
  output logic              irq_out
);

  localparam logic IDLE_LEVEL = 1'b1;

  logic  line_sync;
  logic  det_evt;
  trig_e trig_sel;
  logic  pend_q;
  logic  en_q;
  logic  irq_q;

  nmi_sync #(
    .STAGES    (SYNC_STAGES),
    .RST_LEVEL (IDLE_LEVEL)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_in),
    .sync_out (line_sync)
  );

  nmi_detect #(
    .RST_LEVEL (IDLE_LEVEL)
  ) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_sync (line_sync),
    .trig      (trig_sel),
    .event_o   (det_evt)
  );

  nmi_regs #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .EN_OFFSET (EN_OFFSET)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .event_i   (det_evt),
    .trig_o    (trig_sel),
    .pend_o    (pend_q),
    .en_o      (en_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend_q & en_q;
  end

  assign irq_out = irq_q;

endmodule

// File: rtl/nmi_line_ctrl_chk.sv
module nmi_line_ctrl_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned EN_OFFSET = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              pend,
  input logic              en,
  input logic              evt,
  input logic              irq_out
);

  logic clr_req;
  logic unmapped;
  logic en_wr;

  assign clr_req  = bus_sel & bus_wr & (bus_addr == ADDR_W'(4)) & bus_wdata[0];
  assign en_wr    = bus_sel & bus_wr & (bus_addr == ADDR_W'(EN_OFFSET));
  assign unmapped = (bus_addr != ADDR_W'(0)) && (bus_addr != ADDR_W'(4)) &&
                    (bus_addr != ADDR_W'(EN_OFFSET));

  // R8
  irq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_out == $past(pend & en));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pend);

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr_req) |=> pend);

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && clr_req && !evt) |=> !pend);

  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && unmapped) |-> bus_rdata == '0);

  // R7
  en_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> en == $past(bus_wdata[0]));

endmodule

bind nmi_line_ctrl nmi_line_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .EN_OFFSET (EN_OFFSET)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pend      (pend_q),
  .en        (en_q),
  .evt       (det_evt),
  .irq_out   (irq_out)
);

// File: tb/nmi_line_ctrl_bench.sv
module nmi_line_ctrl_bench;

  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;
  localparam int unsigned EN_OFF = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_in = 1'b1;
  logic          irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  nmi_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .EN_OFFSET(EN_OFF)) u_nmi_line_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic bit lvl(int m, bit v);
    return (m == 0 && !v) || (m == 2 && v);
  endfunction

  function automatic bit edg(int m, bit o, bit n);
    return (m == 1 && o && !n) || (m == 3 && !o && n);
  endfunction

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    logic [DW-1:0] r;
    logic          exp_p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h00, r); chk("R1 ctrl", r, 0);
    rd(8'h04, r); chk("R1 pend", r, 0);
    rd(EN_OFF[AW-1:0], r); chk("R1 en", r, 0);
    chk("R1 irq_out", {31'b0, irq_out}, 0);

    // R2 full-width control readback
    wr(8'h00, 32'hA5A5_5A5E);
    rd(8'h00, r); chk("R2 ctrl readback", r, 32'hA5A5_5A5E);

    // R3 latency, rising edge mode, line idle-high first
    irq_in = 1'b0;
    wr(8'h00, 32'd3);
    repeat (4) @(negedge clk);
    wr(8'h04, 32'd1);
    irq_in = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(8'h04, r); chk("R3 pend not yet after 2 edges", r, 0);
    @(negedge clk);
    rd(8'h04, r); chk("R3 pend after 3rd edge", r, 1);

    // R6 writing 0 to bit 0 keeps flag
    wr(8'h04, 32'hFFFF_FFFE);
    rd(8'h04, r); chk("R6 zero write keeps pend", r, 1);

    // R8 cycle-exact output
    wr(EN_OFF[AW-1:0], 32'hFFFF_FFFF);
    rd(EN_OFF[AW-1:0], r); chk("R7 en reads bit0 only", r, 1);
    chk("R8 irq_out still low", {31'b0, irq_out}, 0);
    @(negedge clk);
    chk("R8 irq_out one cycle later", {31'b0, irq_out}, 1);

    // R9 unmapped offsets
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h34, r); chk("R9 read 0x34", r, 0);
    rd(8'h0C, r); chk("R9 read 0x0C", r, 0);
    rd(8'h00, r); chk("R9 ctrl untouched", r, 3);
    rd(8'h04, r); chk("R9 pend untouched", r, 1);
    rd(EN_OFF[AW-1:0], r); chk("R9 en untouched", r, 1);

    // R2 R4 R5 R6 R8 sweep: mode x old x new x enable
    for (int m = 0; m < 4; m++) begin
      for (int o = 0; o < 2; o++) begin
        for (int n = 0; n < 2; n++) begin
          for (int e = 0; e < 2; e++) begin
            irq_in = o[0];
            wr(8'h00, DW'(m));
            wr(EN_OFF[AW-1:0], DW'(e));
            repeat (4) @(negedge clk);
            wr(8'h04, 32'd1);
            rd(8'h04, r);
            chk($sformatf("R4 clear vs level m%0d o%0d", m, o), r, DW'(lvl(m, o[0])));
            irq_in = n[0];
            repeat (5) @(negedge clk);
            exp_p = lvl(m, o[0]) | lvl(m, n[0]) | edg(m, o[0], n[0]);
            rd(8'h04, r);
            chk($sformatf("R2 R5 pend m%0d o%0d n%0d", m, o, n), r, DW'(exp_p));
            chk($sformatf("R8 irq_out m%0d e%0d", m, e), {31'b0, irq_out}, DW'(exp_p & e[0]));
            wr(8'h04, 32'd1);
            rd(8'h04, r);
            chk($sformatf("R5 R4 re-arm m%0d n%0d", m, n), r, DW'(lvl(m, n[0])));
          end
        end
      end
    end

    done = 1'b1;
    summary();
  end

endmodule